// File: doc/BRIEF.md
# Banked GPIO Expander Register Bank

This block is the device-side register bank of a GPIO expander with a configurable pin count. Each byte register covers eight pins. The number of byte registers in a group is rounded up to a power of two, so 48 pins get the same eight-register layout as 64. A byte-wide register port, normally driven by a serial slave front end, reaches five groups of registers:

- pin direction
- pin level, shared between the driven value and the read-back level
- interrupt enable
- interrupt status
- a reserved group

Input pins pass through a synchroniser. Level changes on inputs latch status bits, which a read clears. An active-high interrupt line rises when an enabled status bit is pending, which gives the host the rising edge it waits for.

Top module: `gpx_regbank`

## Requirements
- R1: After reset the direction, driven value, enable and status registers are all zero. `pin_oe`, `pin_out`, `irq` and `reg_rdata` are low.
- R2: SHIFT is clog2(NUM_PINS)-3, and NUM_PINS must exceed 8. For an address, `reg_addr[ADDR_W-1:SHIFT]` selects the group and the low SHIFT bits select the bank. The groups are 0 = direction, 1 = level, 2 = enable, 3 = status and 4 = reserved. Pin p sits in bank p/8 at bit p%8.
- R3: A write to a direction bank sets `pin_oe` for its eight pins in the next cycle, where 1 means output. The bank reads back as written. `pin_oe` changes only on direction writes.
- R4: A write to a level bank sets `pin_out` for its eight pins in the next cycle, whatever their direction. `pin_out` changes only on level writes.
- R5: A read of a level bank returns the driven value for output pins and the synchronised input level for input pins.
- R6: The enable banks are plain read/write registers.
- R7: A status bit is set when an input pin's synchronised level changes, in either direction. Pins configured as outputs never set status.
- R8: A read of a status bank returns the bank and clears those bits. A change arriving in the same cycle still sets its bit. Writes to status banks are ignored.
- R9: `irq` is the registered OR of status AND enable, one cycle behind those registers.
- R10: The reserved group, groups 5 to 7, and bits of pins at or above NUM_PINS all read zero, and writes to them have no effect.
- R11: `reg_rdata` is loaded in the cycle after `reg_rd` is high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Driven pin values |
| pin_oe | output | NUM_PINS | Output enables (1 = drive) |
| irq | output | 1 | Active-high interrupt to host |

## Verification
The bench aims at the decoder with writes to the upper banks of a 48-pin layout, to the reserved group and to unmapped groups. A wrong shift or bank width would corrupt real pins or return non-zero data for padding. It toggles pins while they are configured as outputs; a design that ignored direction would raise spurious status. It reads status twice to show read-clear, and toggles enable to show `irq` tracks the masked status. A missing clear or a missing mask leaves the line stuck high.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int GRP_W = 3;
  localparam logic [GRP_W-1:0] GRP_DIR = 3'd0;
  localparam logic [GRP_W-1:0] GRP_LVL = 3'd1;
  localparam logic [GRP_W-1:0] GRP_IEN = 3'd2;
  localparam logic [GRP_W-1:0] GRP_STS = 3'd3;
  localparam logic [GRP_W-1:0] GRP_RSV = 3'd4;
endpackage

// File: rtl/gpx_decode.sv
module gpx_decode #(
  parameter int SHIFT  = 3,
  parameter int ADDR_W = SHIFT + gpx_pkg::GRP_W
) (
  input  logic [ADDR_W-1:0]         addr,
  output logic [gpx_pkg::GRP_W-1:0] grp,
  output logic [SHIFT-1:0]          bank
);
  // group index sits above the bank index; bank width follows pin count
  assign grp  = addr[ADDR_W-1 -: gpx_pkg::GRP_W];
  assign bank = addr[SHIFT-1:0];
endmodule

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] chg
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign q   = s2;
  assign chg = s2 ^ s3;
endmodule

// File: rtl/gpx_wreg.sv
module gpx_wreg #(
  parameter int                        NUM_PINS = 48,
  parameter int                        SHIFT    = 3,
  parameter logic [gpx_pkg::GRP_W-1:0] MY_GRP   = gpx_pkg::GRP_DIR
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic [gpx_pkg::GRP_W-1:0] grp,
  input  logic [SHIFT-1:0]          bank,
  input  logic [7:0]                wdata,
  output logic [NUM_PINS-1:0]       q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr && grp == MY_GRP) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (bank == SHIFT'(p >> 3)) q[p] <= wdata[p & 7];
      end
    end
  end
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank #(
  parameter  int NUM_PINS = 48,
  localparam int SHIFT    = $clog2(NUM_PINS) - 3,
  localparam int BANKS    = 1 << SHIFT,
  localparam int PAD      = BANKS * 8,
  localparam int ADDR_W   = SHIFT + gpx_pkg::GRP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  import gpx_pkg::*;

  logic [GRP_W-1:0]    grp;
  logic [SHIFT-1:0]    bank;
  logic [NUM_PINS-1:0] lvl_s, chg_q;
  logic [NUM_PINS-1:0] dir_q, out_q, ien_q;
  logic [NUM_PINS-1:0] st_q, st_d;
  logic [7:0]          rd_byte;

  gpx_decode #(.SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_dec (
    .addr(reg_addr), .grp(grp), .bank(bank)
  );

  gpx_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_s), .chg(chg_q)
  );

  // three writable groups share one register template
  localparam logic [GRP_W-1:0] WGRP [3] = '{GRP_DIR, GRP_LVL, GRP_IEN};
  logic [NUM_PINS-1:0] wq [3];

  for (genvar g = 0; g < 3; g++) begin : g_wreg
    gpx_wreg #(.NUM_PINS(NUM_PINS), .SHIFT(SHIFT), .MY_GRP(WGRP[g])) u_reg (
      .clk(clk), .rst(rst), .wr(reg_wr), .grp(grp), .bank(bank),
      .wdata(reg_wdata), .q(wq[g])
    );
  end

  assign dir_q = wq[0];
  assign out_q = wq[1];
  assign ien_q = wq[2];

  // status: read clears the addressed bank, a fresh input change wins
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      st_d[p] = (st_q[p] & ~(reg_rd && grp == GRP_STS && bank == SHIFT'(p >> 3)))
              | (chg_q[p] & ~dir_q[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  // read path over zero-padded views
  logic [PAD-1:0] v_dir, v_lvl, v_ien, v_sts;
  assign v_dir = PAD'(dir_q);
  assign v_lvl = PAD'((dir_q & out_q) | (~dir_q & lvl_s));
  assign v_ien = PAD'(ien_q);
  assign v_sts = PAD'(st_q);

  always_comb begin
    case (grp)
      GRP_DIR: rd_byte = v_dir[{bank, 3'b000} +: 8];
      GRP_LVL: rd_byte = v_lvl[{bank, 3'b000} +: 8];
      GRP_IEN: rd_byte = v_ien[{bank, 3'b000} +: 8];
      GRP_STS: rd_byte = v_sts[{bank, 3'b000} +: 8];
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h00;
      irq       <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_byte;
      irq <= |(st_q & ien_q);
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpx_regbank_chk.sv
module gpx_regbank_chk #(
  parameter int NUM_PINS = 48
) (
  input logic                      clk,
  input logic                      rst,
  input logic [gpx_pkg::GRP_W-1:0] grp,
  input logic                      reg_wr,
  input logic                      reg_rd,
  input logic [7:0]                reg_rdata,
  input logic [NUM_PINS-1:0]       pin_out,
  input logic [NUM_PINS-1:0]       pin_oe,
  input logic                      irq,
  input logic [NUM_PINS-1:0]       st_q,
  input logic [NUM_PINS-1:0]       ien_q,
  input logic [NUM_PINS-1:0]       chg_q,
  input logic [NUM_PINS-1:0]       dir_q
);
  // R9
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(st_q & ien_q)));

  // R3
  a_r3_oe_hold: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && grp == gpx_pkg::GRP_DIR) |=> $stable(pin_oe));

  // R4
  a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && grp == gpx_pkg::GRP_LVL) |=> $stable(pin_out));

  // R7
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (st_q & ~$past(st_q) & ~$past(chg_q & ~dir_q)) == '0);

  // R10
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && grp >= gpx_pkg::GRP_RSV) |=> reg_rdata == 8'h00);
endmodule

bind gpx_regbank gpx_regbank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .grp(grp), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .st_q(st_q), .ien_q(ien_q), .chg_q(chg_q), .dir_q(dir_q)
);

// File: tb/gpx_regbank_test.sv
`timescale 1ns/1ps
module gpx_regbank_test;
  localparam int N = 48;
  localparam int AW = 6;
  localparam logic [63:0] VALID = 64'h0000_FFFF_FFFF_FFFF;

  logic clk = 0, rst = 1;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;

  always #2.5 clk = ~clk;

  gpx_regbank #(.NUM_PINS(N)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] m_dir = '0, m_out = '0, m_ien = '0, m_st = '0, m_pin = '0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [AW-1:0] a);
    logic [63:0] lvl;
    int b;
    b = int'(a[2:0]) * 8;
    lvl = (m_dir & m_out) | (~m_dir & m_pin);
    case (a[5:3])
      3'd0: return m_dir[b +: 8];
      3'd1: return lvl[b +: 8];
      3'd2: return m_ien[b +: 8];
      3'd3: return m_st[b +: 8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d);
    logic [63:0] m;
    int b;
    b = int'(a[2:0]) * 8;
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    m = '0; m[b +: 8] = d; m = m & VALID;
    case (a[5:3])
      3'd0: m_dir = (m_dir & ~(64'hFF << b)) | m;
      3'd1: m_out = (m_out & ~(64'hFF << b)) | m;
      3'd2: m_ien = (m_ien & ~(64'hFF << b)) | m;
      default: ;
    endcase
  endtask

  task automatic do_rd(input logic [AW-1:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    e = exp_rd(a);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    check(req, {56'd0, reg_rdata}, {56'd0, e});
    if (a[5:3] == 3'd3) m_st = m_st & ~(64'hFF << (int'(a[2:0]) * 8));
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    m_st = m_st | ((64'(v) ^ m_pin) & ~m_dir & VALID);
    m_pin = 64'(v);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_outs(input string req);
    @(negedge clk);
    check(req, 64'(pin_oe), m_dir & VALID);
    check(req, 64'(pin_out), m_out & VALID);
    check(req, {63'd0, irq}, {63'd0, |(m_st & m_ien)});
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", {56'd0, reg_rdata}, 64'd0);
    check("R1", 64'(pin_oe), 64'd0);
    check("R1", 64'(pin_out), 64'd0);
    check("R1", {63'd0, irq}, 64'd0);
    do_rd(6'o00, "R1");
    do_rd(6'o20, "R1");
    // R2 R3 direction and bank placement
    do_wr(6'o00, 8'hA5);
    do_wr(6'o05, 8'h3C);
    chk_outs("R3");
    check("R2", 64'(pin_oe[47:40]), 64'h3C);
    do_rd(6'o05, "R2");
    // R4 driven value
    do_wr(6'o11, 8'hFF);
    chk_outs("R4");
    // R5 R7 input change on pin 3 (input)
    set_pins(48'h8);
    do_rd(6'o10, "R5");
    do_rd(6'o30, "R7");
    do_rd(6'o30, "R8");
    // R7 output pin 0 toggle sets nothing
    set_pins(48'h9);
    do_rd(6'o30, "R7");
    // R6 R9 enable and interrupt
    do_wr(6'o20, 8'h08);
    do_rd(6'o20, "R6");
    set_pins(48'h1);
    chk_outs("R9");
    check("R9", {63'd0, irq}, 64'd1);
    do_wr(6'o30, 8'h00);
    chk_outs("R8");
    do_rd(6'o30, "R8");
    chk_outs("R9");
    check("R9", {63'd0, irq}, 64'd0);
    // R10 reserved, unmapped groups and padding banks
    do_wr(6'o40, 8'hFF);
    do_rd(6'o40, "R10");
    do_wr(6'o60, 8'hFF);
    do_rd(6'o60, "R10");
    do_wr(6'o06, 8'hFF);
    do_rd(6'o06, "R10");
    do_rd(6'o77, "R10");
    chk_outs("R10");
    // R11 read data holds
    do_rd(6'o00, "R11");
    repeat (3) @(negedge clk);
    check("R11", {56'd0, reg_rdata}, {56'd0, m_dir[7:0]});
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [AW-1:0] a;
      op = int'($urandom % 4);
      a = AW'($urandom % 48);
      case (op)
        0: do_wr(a, 8'($urandom));
        1: do_rd(a, "R5");
        2: set_pins(N'({$urandom, $urandom}));
        default: chk_outs("R9");
      endcase
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule